// File: doc/BRIEF.md
# Register-Mapped Transmit and Receive FIFO Bridge

This block sits between a simple register bus and the datapath core of a streaming peripheral. Two word FIFOs of equal width and depth sit inside it. The outbound FIFO is loaded by the bus and unloaded by the core. The inbound FIFO is loaded by the core and unloaded by the bus.

Each FIFO has exactly one bus address. Because of that, the bus access itself moves the FIFO. A write to the outbound data address enqueues one word. A read of the inbound data address returns the oldest word and dequeues it in the same access. On the core side, a one-cycle strobe with a data word enqueues into the inbound FIFO. A one-cycle strobe dequeues from the outbound FIFO, and the word appears on the core's data output on the following cycle.

Full and empty flags for both FIFOs are driven as ports. They can also be read through a status address. Bus reads answer one cycle later, with a valid pulse.

Top module: `fifo_regbridge`

## Requirements
- R1: After a synchronous active-high reset, both FIFOs are empty and not full, and `bus_rdata`, `bus_rvalid` and `core_tx_data` are zero.
- R2: A bus write to address 0x0 enqueues the low DATA_W bits of `bus_wdata` into the outbound FIFO. Bus writes to address 0x4 or 0x8 change neither FIFO.
- R3: Each `core_tx_pop` pulse dequeues the oldest outbound word. That word is on `core_tx_data` from the clock edge that samples the pulse until the next pop.
- R4: Each `core_rx_push` pulse enqueues `core_rx_data` into the inbound FIFO. A bus read of address 0x4 returns the oldest inbound word on `bus_rdata` and dequeues it. The word is zero-extended to BUS_W, and `bus_rvalid` is high in the cycle after the read.
- R5: Each FIFO holds DEPTH (default 16) words. The full flag rises on the DEPTH-th stored word. A push while full is dropped, and the stored contents and order stay intact.
- R6: A pop from an empty FIFO yields zero, on `core_tx_data` or on `bus_rdata` respectively. It does not disturb later ordering.
- R7: A bus read of address 0x8 returns the flags as they were in the read cycle: bit 0 outbound full, bit 1 outbound empty, bit 2 inbound full, bit 3 inbound empty. All other bits are zero.
- R8: A push and a pop in the same cycle on a FIFO that is neither empty nor full leave its occupancy unchanged. On an empty FIFO, the pop yields zero and the push is kept.
- R9: Word width is DATA_W (default 9). Bus write bits above DATA_W are discarded, and read data bits above DATA_W are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | BUS_W | Bus write data |
| bus_rdata | output | BUS_W | Bus read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd_en |
| core_rx_push | input | 1 | Core strobe: enqueue into inbound FIFO |
| core_rx_data | input | DATA_W | Core word for the inbound FIFO |
| core_tx_pop | input | 1 | Core strobe: dequeue from outbound FIFO |
| core_tx_data | output | DATA_W | Word dequeued by the last core_tx_pop |
| tx_full | output | 1 | Outbound FIFO full |
| tx_empty | output | 1 | Outbound FIFO empty |
| rx_full | output | 1 | Inbound FIFO full |
| rx_empty | output | 1 | Inbound FIFO empty |

## Verification
Short bursts of distinct words through each FIFO show that ordering and data are right under light load.

Overfilling each FIFO by a few words, then draining it, separates a dropped push from an overwritten slot. Popping an empty FIFO, then refilling it, shows whether a stray pointer move happened.

Same-cycle push and pop, at mid occupancy and again on an empty FIFO, reveals miscounting: the full flag is made to rise on an exact word count afterwards. Writes with all-ones upper bits, and writes to the wrong addresses, separate width truncation and address decoding from the FIFO logic.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_TXDATA = 4'h0;
  localparam logic [ADDR_W-1:0] A_RXDATA = 4'h4;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'h8;

  localparam int unsigned STAT_W = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RX   = 2'd1,
    SEL_STAT = 2'd2
  } rsel_e;

  typedef struct packed {
    logic rx_empty;
    logic rx_full;
    logic tx_empty;
    logic tx_full;
  } stat_t;
endpackage

// File: rtl/frb_fifo.sv
module frb_fifo #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [DATA_W-1:0] ram_q;
  logic              hit_q;
  logic              push_ok, pop_ok;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) &&
                   (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // storage and read port kept free of reset so a RAM primitive can be used
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) ram_q <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)      hit_q <= 1'b0;
    else if (pop) hit_q <= !empty;
  end

  assign dout = hit_q ? ram_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (wr_ptr == $past(wr_ptr)));

  p_flags_apart_r5: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> ((rd_ptr == $past(rd_ptr)) && (dout == '0)));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !full && !empty) |=>
      ((wr_ptr - rd_ptr) == $past(wr_ptr - rd_ptr)));
endmodule

// File: rtl/frb_bus_regs.sv
module frb_bus_regs
  import frb_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned BUS_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic                 bus_rvalid,
  output logic                 tx_push,
  output logic [DATA_W-1:0]    tx_din,
  output logic                 rx_pop,
  input  logic [DATA_W-1:0]    rx_dout,
  input  stat_t                stat
);
  localparam int unsigned PAD_D = BUS_W - DATA_W;
  localparam int unsigned PAD_S = BUS_W - STAT_W;

  rsel_e sel_q;
  stat_t stat_q;
  logic  rvalid_q;

  assign tx_push = bus_wr_en && (bus_addr == A_TXDATA);
  assign tx_din  = bus_wdata[DATA_W-1:0];
  assign rx_pop  = bus_rd_en && (bus_addr == A_RXDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_NONE;
      stat_q   <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_en;
      sel_q    <= SEL_NONE;
      if (bus_rd_en) begin
        if (bus_addr == A_RXDATA)      sel_q <= SEL_RX;
        else if (bus_addr == A_STATUS) sel_q <= SEL_STAT;
        stat_q <= stat;
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_RX:   bus_rdata = {{PAD_D{1'b0}}, rx_dout};
      SEL_STAT: bus_rdata = {{PAD_S{1'b0}}, stat_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign bus_rvalid = rvalid_q;

  p_rvalid_r4: assert property (@(posedge clk) disable iff (rst)
    bus_rd_en |=> bus_rvalid);

  p_status_snap_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (bus_addr == A_STATUS)) |=>
      (bus_rdata == {{PAD_S{1'b0}}, $past(stat)}));
endmodule

// File: rtl/fifo_regbridge.sv
module fifo_regbridge
  import frb_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              core_rx_push,
  input  logic [DATA_W-1:0] core_rx_data,
  input  logic              core_tx_pop,
  output logic [DATA_W-1:0] core_tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty
);
  logic              tx_push, rx_pop;
  logic [DATA_W-1:0] tx_din, rx_dout;
  stat_t             stat;

  assign stat.tx_full  = tx_full;
  assign stat.tx_empty = tx_empty;
  assign stat.rx_full  = rx_full;
  assign stat.rx_empty = rx_empty;

  frb_bus_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .tx_push    (tx_push),
    .tx_din     (tx_din),
    .rx_pop     (rx_pop),
    .rx_dout    (rx_dout),
    .stat       (stat)
  );

  frb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (tx_push),
    .din   (tx_din),
    .pop   (core_tx_pop),
    .dout  (core_tx_data),
    .full  (tx_full),
    .empty (tx_empty)
  );

  frb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (core_rx_push),
    .din   (core_rx_data),
    .pop   (rx_pop),
    .dout  (rx_dout),
    .full  (rx_full),
    .empty (rx_empty)
  );

  p_wrong_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && (bus_addr != A_TXDATA) && !core_tx_pop) |=>
      (tx_empty == $past(tx_empty)));
endmodule

// File: tb/fifo_regbridge_tb.sv
`timescale 1ns/1ps
module fifo_regbridge_tb;
  localparam int DW = 9;
  localparam int DEPTH = 16;
  localparam int BW = 32;
  localparam logic [3:0] ATX = 4'h0, ARX = 4'h4, AST = 4'h8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr_en = 0, bus_rd_en = 0;
  logic [3:0] bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic bus_rvalid;
  logic core_rx_push = 0, core_tx_pop = 0;
  logic [DW-1:0] core_rx_data = '0;
  logic [DW-1:0] core_tx_data;
  logic tx_full, tx_empty, rx_full, rx_empty;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] txq[$], rxq[$];

  always #2.5 clk = ~clk;

  fifo_regbridge u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .core_rx_push(core_rx_push),
    .core_rx_data(core_rx_data), .core_tx_pop(core_tx_pop),
    .core_tx_data(core_tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty)
  );

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected items queued after the edge
  task automatic step(input logic bw, input logic br, input logic [3:0] a,
                      input logic [BW-1:0] wd, input logic cpush,
                      input logic [DW-1:0] cd, input logic cpop);
    @(negedge clk);
    bus_wr_en = bw; bus_rd_en = br; bus_addr = a; bus_wdata = wd;
    core_rx_push = cpush; core_rx_data = cd; core_tx_pop = cpop;
    @(posedge clk);
    #1;
    if (bw && a == ATX && txq.size() < DEPTH) txq.push_back(wd[DW-1:0]);
    if (cpush && rxq.size() < DEPTH) rxq.push_back(cd);
    bus_wr_en = 0; bus_rd_en = 0; core_rx_push = 0; core_tx_pop = 0;
  endtask

  task automatic bwr(input logic [3:0] a, input logic [BW-1:0] d);
    step(1, 0, a, d, 0, '0, 0);
  endtask
  task automatic brd(input logic [3:0] a);
    step(0, 1, a, '0, 0, '0, 0);
  endtask
  task automatic cpush(input logic [DW-1:0] d);
    step(0, 0, '0, '0, 1, d, 0);
  endtask
  task automatic cpop();
    step(0, 0, '0, '0, 0, '0, 1);
  endtask

  task automatic chk_flags(input string req);
    @(negedge clk); #1;
    chk({req, " flags"}, {28'd0, rx_empty, rx_full, tx_empty, tx_full},
        {28'd0, rxq.size() == 0, rxq.size() == DEPTH,
         txq.size() == 0, txq.size() == DEPTH});
  endtask

  // monitor: samples what was issued at each edge, compares after it
  logic m_rd = 0, m_rx = 0, m_st = 0, m_pop = 0, m_txe = 0, m_rxe = 0;
  logic [3:0] m_stat = '0;
  always @(posedge clk) begin
    m_rd   <= bus_rd_en;
    m_rx   <= bus_rd_en && bus_addr == ARX;
    m_st   <= bus_rd_en && bus_addr == AST;
    m_pop  <= core_tx_pop;
    m_txe  <= txq.size() == 0;
    m_rxe  <= rxq.size() == 0;
    m_stat <= {rxq.size() == 0, rxq.size() == DEPTH, txq.size() == 0, txq.size() == DEPTH};
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [DW-1:0] e;
      if (m_rd) chk("R4 rvalid", {31'd0, bus_rvalid}, 32'd1);
      if (m_rx) begin
        e = m_rxe ? '0 : rxq.pop_front();
        chk(m_rxe ? "R6 rx empty read" : "R4 rx read", bus_rdata, {23'd0, e});
      end
      if (m_st) chk("R7 status", bus_rdata, {28'd0, m_stat});
      if (m_pop) begin
        e = m_txe ? '0 : txq.pop_front();
        chk(m_txe ? "R6 tx empty pop" : "R3 tx pop", {23'd0, core_tx_data}, {23'd0, e});
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 rdata", bus_rdata, '0);
    chk("R1 rvalid", {31'd0, bus_rvalid}, '0);
    chk("R1 txdata", {23'd0, core_tx_data}, '0);
    chk_flags("R1");

    // R3: ordered outbound transfer, then R6 empty pop and recovery
    bwr(ATX, 32'h011); bwr(ATX, 32'h0A2); bwr(ATX, 32'h1F3);
    brd(AST);
    cpop(); cpop(); cpop();
    cpop();
    bwr(ATX, 32'h155); cpop();
    chk_flags("R6");

    // R2: writes to other addresses ignored
    bwr(ARX, 32'h0AA); bwr(AST, 32'h0FF);
    chk_flags("R2");
    brd(ARX);

    // R4: inbound transfer, R6 empty read
    for (int i = 0; i < 4; i++) cpush(DW'(9'h030 + i * 7));
    brd(AST);
    for (int i = 0; i < 4; i++) brd(ARX);
    brd(ARX);

    // R5: overfill outbound, status, drain
    for (int i = 0; i < DEPTH + 2; i++) bwr(ATX, BW'(i * 13 + 1));
    chk_flags("R5 tx full");
    brd(AST);
    for (int i = 0; i < DEPTH; i++) cpop();
    chk_flags("R5 tx drained");

    // R5: overfill inbound, drain
    for (int i = 0; i < DEPTH + 1; i++) cpush(DW'(i * 29 + 3));
    chk_flags("R5 rx full");
    brd(AST);
    for (int i = 0; i < DEPTH; i++) brd(ARX);
    chk_flags("R5 rx drained");

    // R8: simultaneous push/pop keeps occupancy
    for (int i = 0; i < 5; i++) cpush(DW'(9'h100 + i));
    for (int i = 0; i < 3; i++) step(0, 1, ARX, '0, 1, DW'(9'h0C0 + i), 0);
    for (int i = 0; i < 10; i++) cpush(DW'(9'h050 + i));
    chk_flags("R8 one short of full");
    cpush(9'h1EE);
    chk_flags("R8 full");
    for (int i = 0; i < DEPTH; i++) brd(ARX);
    bwr(ATX, 32'h021); bwr(ATX, 32'h022);
    step(1, 0, ATX, 32'h023, 0, '0, 1);
    step(0, 0, '0, '0, 0, '0, 1);
    step(0, 0, '0, '0, 0, '0, 1);
    chk_flags("R8 tx drained");
    // R8: push and pop together on empty FIFOs
    step(1, 0, ATX, 32'h0B7, 0, '0, 1);
    step(0, 1, ARX, '0, 1, 9'h0C9, 0);
    cpop(); brd(ARX);
    chk_flags("R8 empty case");

    // R9: upper bits dropped, read data zero-extended
    bwr(ATX, 32'hFFFF_FFFF); cpop();
    bwr(ATX, 32'hABCD_E05A); cpop();
    cpush(9'h1FF); brd(ARX);
    @(negedge clk); @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule